// File: doc/BRIEF.md
# Half-Integer and Fractional Clock-Enable Divider

This block turns a fast source clock into a slower stream of clock-enable pulses. It has two stages. The first stage divides by a ratio that may end in one half. The second stage is optional: it thins the first stage's pulses so that exactly M of them pass for every N. Together the two stages give fractional rates without a second clock domain. Odd half-integer ratios are made by alternating between the shorter and the longer whole-cycle period, so that the average over two periods is exact.

A controller drives the configuration fields in their stored forms. The divider field holds twice the ratio minus one. M is stored directly. The N field holds the complement of N−M. The duty field holds the complement of N. Raising the update strobe for one cycle captures a new set of fields. The running period always completes first: the new values take effect only at the next first-stage pulse, and both accumulators restart there. Besides the pulse stream, the block gives a level output for the fractional mode. This level is high while the fractional phase lies in the lower half of the N period, which gives a clock of roughly even duty at the M/N rate.

Top module: `frac_clk_div`

## Requirements
- R1: After reset the divider field, the mode and M are all zero, `div_tick` and `clk_en` are high in every cycle, and `clk_lvl` is low.
- R2: With divider field v ≥ 1, `div_tick` pulses exactly twice in any v+1 consecutive cycles. With v = 0, it pulses in every cycle.
- R3: For even v ≥ 2, the gaps between successive `div_tick` pulses alternate between v/2 and v/2+1 cycles. For odd v, every gap is (v+1)/2 cycles.
- R4: With mode ≠ 0, `clk_en` pulses exactly M times in any span of N `div_tick` pulses, where N = (bitwise complement of `cfg_n`) + M. A `clk_en` pulse only falls in a cycle where `div_tick` is high.
- R5: With mode = 0, `clk_en` equals `div_tick` whatever M, N and D hold, and `clk_lvl` stays low.
- R6: With mode ≠ 0, `clk_lvl` is high while the phase accumulator is below half of the complement of `cfg_d`. When div = 0 and M and N are coprime, that is exactly floor(N/2) cycles out of every N.
- R7: A one-cycle `cfg_update` captures all fields. They take effect only at the next `div_tick`, so the period under way keeps its old length and the following one has the new length.
- R8: With mode ≠ 0 and M = 0, `clk_en` never pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_update | input | 1 | One-cycle strobe that captures the fields below |
| cfg_div | input | DIV_W | First-stage ratio encoded as 2·ratio−1; 0 bypasses the stage |
| cfg_mode | input | 2 | 0 bypasses the M/N stage; 2 selects dual-edge fractional counting |
| cfg_m | input | MN_W | M, stored directly |
| cfg_n | input | MN_W | Complement of N−M |
| cfg_d | input | MN_W | Complement of N, the duty threshold source |
| div_tick | output | 1 | First-stage pulse |
| clk_en | output | 1 | Final clock-enable pulse |
| clk_lvl | output | 1 | Fractional clock level, low in mode 0 |

## Verification
The assertions assume two things about the fields whenever the mode is non-zero: the decoded N is at least one and fits in MN_W bits, and the duty field holds the complement of that same N. The phase bound and the no-pulse rule for M = 0 depend on both. The stimulus encodes every random setting from a chosen M and N−M, so the duty field always matches N. It keeps M at one or more and M+N−M below 2^MN_W. The only case with M = 0 is directed, and it leaves N−M non-zero.

// File: rtl/frac_clk_div_pkg.sv
// Package: shared encodings for the fractional clock-enable divider.
// Assumes: the mode field is two bits wide, and any non-zero value enables M/N.
package frac_clk_div_pkg;

    typedef enum logic [1:0] {
        MODE_BYPASS = 2'd0,
        MODE_SPARE1 = 2'd1,
        MODE_DUAL   = 2'd2,
        MODE_SPARE3 = 2'd3
    } mn_mode_e;

    // Returns whether the fractional stage counts in this mode.
    function automatic logic mode_active(input logic [1:0] mode);
        return mode != MODE_BYPASS;
    endfunction

endpackage

// File: rtl/fdiv_cfg_hold.sv
// Module: holds the active configuration and takes up a captured update only at a boundary.
// Assumes: boundary is the first-stage pulse, so a change never lands mid-period.
module fdiv_cfg_hold #(
    parameter int DIV_W = 5,
    parameter int MN_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd,
    input  logic [DIV_W-1:0] in_div,
    input  logic [1:0]       in_mode,
    input  logic [MN_W-1:0]  in_m,
    input  logic [MN_W-1:0]  in_n,
    input  logic [MN_W-1:0]  in_d,
    input  logic             boundary,
    output logic             load,
    output logic [DIV_W-1:0] act_div,
    output logic [1:0]       act_mode,
    output logic [MN_W-1:0]  act_m,
    output logic [MN_W-1:0]  act_n,
    output logic [MN_W-1:0]  act_d
);

    logic             pend;
    logic [DIV_W-1:0] sh_div;
    logic [1:0]       sh_mode;
    logic [MN_W-1:0]  sh_m, sh_n, sh_d;

    assign load = pend && boundary;

    // Captures fields on the strobe and copies them to the active set at a boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend     <= 1'b0;
            sh_div   <= '0;
            sh_mode  <= '0;
            sh_m     <= '0;
            sh_n     <= '0;
            sh_d     <= '0;
            act_div  <= '0;
            act_mode <= '0;
            act_m    <= '0;
            act_n    <= '0;
            act_d    <= '0;
        end else begin
            if (load) begin
                act_div  <= sh_div;
                act_mode <= sh_mode;
                act_m    <= sh_m;
                act_n    <= sh_n;
                act_d    <= sh_d;
                pend     <= upd;
            end else if (upd) begin
                pend <= 1'b1;
            end
            if (upd) begin
                sh_div  <= in_div;
                sh_mode <= in_mode;
                sh_m    <= in_m;
                sh_n    <= in_n;
                sh_d    <= in_d;
            end
        end
    end

    // R7: the active ratio changes only in the cycle after a boundary.
    p_cfg_at_boundary_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (act_div != $past(act_div)) |-> $past(boundary));

    // R7: the active M changes only in the cycle after a boundary.
    p_m_at_boundary_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (act_m != $past(act_m)) |-> $past(boundary));

endmodule

// File: rtl/fdiv_half_stage.sv
// Module: first stage, divides by (div+1)/2 using a half-cycle phase accumulator.
// Assumes: the accumulator is cleared whenever a new ratio is loaded.
module fdiv_half_stage #(
    parameter int DIV_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    input  logic             load,
    output logic             tick
);

    localparam int AW = DIV_W + 1;

    logic [AW-1:0] acc, acc_add, lim;

    assign acc_add = acc + AW'(2);
    assign lim     = {1'b0, div} + AW'(1);
    assign tick    = (div == '0) || (acc_add >= lim);

    // Adds two half-cycles per source cycle and subtracts the period on each pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || load || div == '0) begin
            acc <= '0;
        end else if (tick) begin
            acc <= acc_add - lim;
        end else begin
            acc <= acc_add;
        end
    end

    // R2: the phase never reaches the period length.
    p_phase_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        acc <= {1'b0, div});

    // R3: for ratios of two or more, pulses are never back to back.
    p_no_adjacent_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div >= DIV_W'(3) && !load) |=> !tick);

endmodule

// File: rtl/fdiv_mn_stage.sv
// Module: fractional stage, passes M of every N input pulses and makes a duty level.
// Assumes: when active, the decoded N is at least 1, and the duty field is the complement of N.
module fdiv_mn_stage #(
    parameter int MN_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            step,
    input  logic            load,
    input  logic [1:0]      mode,
    input  logic [MN_W-1:0] m,
    input  logic [MN_W-1:0] n_enc,
    input  logic [MN_W-1:0] d_enc,
    output logic            en,
    output logic            lvl
);

    import frac_clk_div_pkg::*;

    localparam int AW = MN_W + 2;

    logic          active, wrap;
    logic [AW-1:0] macc, sum, n_mod, d_half;

    assign active = mode_active(mode);
    assign n_mod  = {2'b00, ~n_enc} + {2'b00, m};
    assign d_half = {2'b00, ~d_enc} >> 1;
    assign sum    = macc + {2'b00, m};
    assign wrap   = sum >= n_mod;
    assign en     = step && (!active || wrap);
    assign lvl    = active && (macc < d_half);

    // Adds M on each input pulse and takes the result modulo N.
    always_ff @(posedge clk) begin
        if (!rst_n || load || !active) begin
            macc <= '0;
        end else if (step) begin
            macc <= wrap ? (sum - n_mod) : sum;
        end
    end

    // R4: while counting, the phase stays below the modulus.
    p_phase_below_n_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (active && n_mod != '0) |-> (macc < n_mod));

    // R8: with M of zero and a non-zero modulus, no pulse passes.
    p_m_zero_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (active && m == '0 && n_mod != '0) |-> !en);

    // R5: in bypass mode the level stays low.
    p_bypass_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !lvl);

endmodule

// File: rtl/frac_clk_div.sv
// Module: top of the fractional clock-enable divider: config hold, half-integer stage, M/N stage.
// Assumes: single source clock; all outputs are combinational from registered state.
module frac_clk_div #(
    parameter int DIV_W = 5,
    parameter int MN_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_update,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic [1:0]       cfg_mode,
    input  logic [MN_W-1:0]  cfg_m,
    input  logic [MN_W-1:0]  cfg_n,
    input  logic [MN_W-1:0]  cfg_d,
    output logic             div_tick,
    output logic             clk_en,
    output logic             clk_lvl
);

    logic             load;
    logic [DIV_W-1:0] a_div;
    logic [1:0]       a_mode;
    logic [MN_W-1:0]  a_m, a_n, a_d;

    fdiv_cfg_hold #(.DIV_W(DIV_W), .MN_W(MN_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .upd(cfg_update),
        .in_div(cfg_div), .in_mode(cfg_mode), .in_m(cfg_m), .in_n(cfg_n), .in_d(cfg_d),
        .boundary(div_tick), .load(load),
        .act_div(a_div), .act_mode(a_mode), .act_m(a_m), .act_n(a_n), .act_d(a_d)
    );

    fdiv_half_stage #(.DIV_W(DIV_W)) u_half (
        .clk(clk), .rst_n(rst_n), .div(a_div), .load(load), .tick(div_tick)
    );

    fdiv_mn_stage #(.MN_W(MN_W)) u_mn (
        .clk(clk), .rst_n(rst_n), .step(div_tick), .load(load), .mode(a_mode),
        .m(a_m), .n_enc(a_n), .d_enc(a_d), .en(clk_en), .lvl(clk_lvl)
    );

    // R4: a final pulse only falls on a first-stage pulse.
    p_en_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en |-> div_tick);

endmodule

// File: tb/tb_frac_clk_div.sv
module tb_frac_clk_div;

    localparam int CLK_PERIOD = 10;
    localparam int DIV_W = 5;
    localparam int MN_W  = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_update = 1'b0;
    logic [DIV_W-1:0] cfg_div = '0;
    logic [1:0]       cfg_mode = '0;
    logic [MN_W-1:0]  cfg_m = '0, cfg_n = '0, cfg_d = '0;
    logic             div_tick, clk_en, clk_lvl;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    frac_clk_div #(.DIV_W(DIV_W), .MN_W(MN_W)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_update(cfg_update),
        .cfg_div(cfg_div), .cfg_mode(cfg_mode), .cfg_m(cfg_m), .cfg_n(cfg_n), .cfg_d(cfg_d),
        .div_tick(div_tick), .clk_en(clk_en), .clk_lvl(clk_lvl)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Cycles in one base window of the first stage.
    function automatic int base_cycles(input int div);
        return (div == 0) ? 1 : div + 1;
    endfunction

    // Ticks in one base window.
    function automatic int base_ticks(input int div);
        return (div == 0) ? 1 : 2;
    endfunction

    task automatic apply(input int div, input int mode, input int m, input int nm);
        logic [MN_W-1:0] nm_v, nn_v;
        nm_v = MN_W'(nm);
        nn_v = MN_W'(m + nm);
        @(negedge clk);
        cfg_div = DIV_W'(div);
        cfg_mode = 2'(mode);
        cfg_m = MN_W'(m);
        cfg_n = ~nm_v;
        cfg_d = ~nn_v;
        cfg_update = 1'b1;
        @(negedge clk);
        cfg_update = 1'b0;
        repeat (40) @(negedge clk);
    endtask

    task automatic count(input int cycles, output int nt, output int ne, output int nl);
        nt = 0; ne = 0; nl = 0;
        for (int i = 0; i < cycles; i++) begin
            nt += int'(div_tick);
            ne += int'(clk_en);
            nl += int'(clk_lvl);
            @(negedge clk);
        end
    endtask

    task automatic check_rates(input int div, input int mode, input int m, input int nm);
        int n, w, nt, ne, nl;
        n = (mode != 0) ? m + nm : 1;
        w = base_cycles(div) * n;
        count(w, nt, ne, nl);
        check("R2 ticks per window", nt, base_ticks(div) * n);
        if (mode != 0) check("R4 pulses per N ticks", ne, base_ticks(div) * m);
        else begin
            check("R5 enable follows tick", ne, nt);
            check("R5 level low in bypass", nl, 0);
        end
    endtask

    task automatic check_gaps(input int div);
        int g, prev;
        while (!div_tick) @(negedge clk);
        prev = -1;
        for (int k = 0; k < 4; k++) begin
            g = 0;
            do begin @(negedge clk); g++; end while (!div_tick);
            if (div % 2 == 1) check("R3 odd gap", g, (div + 1) / 2);
            else if (prev >= 0) check("R3 gap pair sum", g + prev, div + 1);
            prev = g;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int nt, ne, nl, g;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        count(8, nt, ne, nl);
        check("R1 tick every cycle", nt, 8);
        check("R1 enable every cycle", ne, 8);
        check("R1 level low", nl, 0);

        // Directed R3 gaps
        apply(6, 0, 0, 0);  check_gaps(6);
        apply(7, 0, 0, 0);  check_gaps(7);
        apply(2, 0, 0, 0);  check_gaps(2);

        // Directed R6 duty level with coprime M,N at div 0
        apply(0, 2, 3, 5);
        count(8, nt, ne, nl);
        check("R6 level high cycles N=8", nl, 4);
        check("R4 pulses M=3 N=8", ne, 3);
        apply(0, 2, 1, 4);
        count(5, nt, ne, nl);
        check("R6 level high cycles N=5", nl, 2);

        // R8: M of zero
        apply(3, 2, 0, 7);
        count(64, nt, ne, nl);
        check("R8 no pulses with M=0", ne, 0);

        // R5: bypass ignores M/N/D
        apply(4, 0, 9, 13);
        check_rates(4, 0, 9, 13);

        // R7: change lands at the boundary
        apply(7, 0, 0, 0);
        while (!div_tick) @(negedge clk);
        cfg_div = DIV_W'(15);
        cfg_update = 1'b1;
        @(negedge clk);
        cfg_update = 1'b0;
        g = 1;
        while (!div_tick) begin @(negedge clk); g++; end
        check("R7 running period keeps old length", g, 4);
        g = 0;
        do begin @(negedge clk); g++; end while (!div_tick);
        check("R7 next period uses new length", g, 8);

        // Random configurations
        for (int t = 0; t < 24; t++) begin
            int div, mode, m, nm;
            div  = int'($urandom % 32);
            mode = ($urandom % 3 == 0) ? 0 : 2;
            m    = 1 + int'($urandom % 20);
            nm   = int'($urandom % 31);
            apply(div, mode, m, nm);
            check_rates(div, mode, m, nm);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule